// File: doc/BRIEF.md
# Codec Control Register Port

This block sits behind the serial frame deserializer of an audio codec and serves the command and status traffic of a bidirectional frame link. It is given the fields of the two command slots of each incoming frame as parallel words, together with the frame's valid and slot tag bits, on a one-cycle frame strobe. A write updates a bank of 16-bit control registers addressed by a 7-bit even index. A read is answered through the two status slots of the outgoing frame that starts at the next frame strobe.

The bank holds the mixer level and gain registers, with mute flags, per-field masking and saturation of an unsupported sixth level bit. It also holds the power-down register, whose control bits drive outputs and whose readiness bits are derived from those controls and cannot be written. An asynchronous cold reset restores every default. A write of any value to index 00h restores the same defaults.

Top module: `codec_reg_port`

## Requirements
- R1: A command is taken only on a cycle where frame_stb and frame_valid are both 1 and cmd_tag[1] (command address slot tag) is 1. cmd_addr[19] set to 1 marks a read and set to 0 marks a write. cmd_addr[18:12] is the index. A write also needs cmd_tag[0] (command data slot tag) and takes its 16-bit value from cmd_data[19:4].
- R2: A command whose index is odd (cmd_addr[12] = 1) is ignored. It changes no register and produces no read response.
- R3: The response to a read appears at the next frame strobe, and the outputs change only at frame strobes. It shows sts_tag = 2'b11 (bit 1 for the address slot, bit 0 for the data slot), sts_slot1 = {0, index, 12 zeros} and sts_slot2 = {data, 4 zeros}. At a strobe with no read pending, both slots are zero and sts_tag = 2'b00.
- R4: When a write lands at the same strobe that sends a response, the response carries the value held before that write. This holds for a write to the register being read and for a write to index 00h.
- R5: Registers 02h and 04h keep a mute flag in bit 15 and 5-bit level fields in bits 12:8 and 4:0. If a written field has its sixth bit set (bit 13 or bit 5), that field is stored as 11111 and the sixth bit reads 0. All other bits read 0.
- R6: Registers 10h, 12h, 16h and 18h keep bits 15, 12:8 and 4:0. Register 0Eh keeps mute in bit 15, the boost enable in bit 6 and gain in bits 4:0. All other bits read 0.
- R7: Register 1Ch keeps mute in bit 15 and 4-bit fields in bits 11:8 and 3:0. All other bits read 0.
- R8: In register 26h, bits 14:8 are written and drive pd_ctrl[6:0], and link_halt follows bit 12. Bits 3:0 read back as readiness flags and ignore written data. Bit 3 is cleared by bit 11. Bit 2 is cleared by bit 10 or bit 11. Bit 1 is cleared by bit 9. Bit 0 is cleared by bit 8.
- R9: After a cold reset, the outputs are zero and the registers read back as follows: 02h and 04h read 8000h, 0Eh reads 8008h, 10h/12h/16h/18h read 8808h, 1Ch reads 8000h and 26h reads 000Fh. Any other even index reads 0000h.
- R10: A write of any value to index 00h restores every R9 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| frame_stb | input | 1 | One-cycle pulse per frame carrying the command slot fields |
| frame_valid | input | 1 | Frame valid bit of the incoming tag slot |
| cmd_tag | input | 2 | Slot tags: [1] command address slot, [0] command data slot |
| cmd_addr | input | 8 | Command address slot bits 19:12 (read flag, index) |
| cmd_data | input | 16 | Command data slot bits 19:4 (write value) |
| sts_slot1 | output | 20 | Status address slot of the outgoing frame |
| sts_slot2 | output | 20 | Status data slot of the outgoing frame |
| sts_tag | output | 2 | Status slot tags: [1] address slot, [0] data slot |
| pd_ctrl | output | 7 | Power-down control bits from register 26h bits 14:8 |
| link_halt | output | 1 | Link power-down request |

## Verification
Two events can fall on the same frame strobe: sending the pending read response and committing a new write. The bench provokes this by issuing a read of 12h and, in the very next frame, a write of 0000h to 12h. Later it repeats the pattern with a read followed at once by a write to the reset index. Each response is judged against the value held before the colliding write. A following read must then show the new value or the default.

// File: rtl/codec_reg_port.sv
module codec_reg_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_stb,
  input  logic        frame_valid,
  input  logic [1:0]  cmd_tag,
  input  logic [19:12] cmd_addr,
  input  logic [19:4] cmd_data,
  output logic [19:0] sts_slot1,
  output logic [19:0] sts_slot2,
  output logic [1:0]  sts_tag,
  output logic [6:0]  pd_ctrl,
  output logic        link_halt
);
  localparam logic [6:0] IX_RESET  = 7'h00;
  localparam logic [6:0] IX_MASTER = 7'h02;
  localparam logic [6:0] IX_HPHONE = 7'h04;
  localparam logic [6:0] IX_MIC    = 7'h0E;
  localparam logic [6:0] IX_LINE   = 7'h10;
  localparam logic [6:0] IX_CD     = 7'h12;
  localparam logic [6:0] IX_AUX    = 7'h16;
  localparam logic [6:0] IX_PCM    = 7'h18;
  localparam logic [6:0] IX_REC    = 7'h1C;
  localparam logic [6:0] IX_PWR    = 7'h26;

  localparam logic [15:0] DEF_LVL  = 16'h8000;
  localparam logic [15:0] DEF_MIC  = 16'h8008;
  localparam logic [15:0] DEF_GAIN = 16'h8808;
  localparam logic [15:0] DEF_REC  = 16'h8000;

  localparam logic [15:0] MSK_LVL  = 16'hBF3F;
  localparam logic [15:0] MSK_MIC  = 16'h805F;
  localparam logic [15:0] MSK_GAIN = 16'h9F1F;
  localparam logic [15:0] MSK_REC  = 16'h8F0F;
  localparam logic [15:0] MSK_PWR  = 16'h7F00;

  function automatic logic [4:0] sat5(input logic [5:0] f);
    return f[5] ? 5'h1F : f[4:0];
  endfunction

  function automatic logic [15:0] lvl_pack(input logic [15:0] d);
    logic [15:0] m;
    m = d & MSK_LVL;
    return {m[15], 2'b00, sat5(m[13:8]), 3'b000, sat5(m[5:0])};
  endfunction

  logic [15:0] r_master, r_hphone, r_mic, r_line, r_cd, r_aux, r_pcm, r_rec;
  logic [6:0]  r_pwr;
  logic        pend_rd;
  logic [6:0]  pend_idx;
  logic [15:0] rd_val;
  logic [3:0]  ready;

  wire [6:0]  idx    = cmd_addr[18:12];
  wire [15:0] wd     = cmd_data;
  wire        cmd_ok = frame_stb & frame_valid & cmd_tag[1] & ~cmd_addr[12];
  wire        do_rd  = cmd_ok & cmd_addr[19];
  wire        do_wr  = cmd_ok & ~cmd_addr[19] & cmd_tag[0];

  assign ready     = {~r_pwr[3], ~(r_pwr[2] | r_pwr[3]), ~r_pwr[1], ~r_pwr[0]};
  assign pd_ctrl   = r_pwr;
  assign link_halt = r_pwr[4];

  always_comb begin
    case (pend_idx)
      IX_MASTER: rd_val = r_master;
      IX_HPHONE: rd_val = r_hphone;
      IX_MIC:    rd_val = r_mic;
      IX_LINE:   rd_val = r_line;
      IX_CD:     rd_val = r_cd;
      IX_AUX:    rd_val = r_aux;
      IX_PCM:    rd_val = r_pcm;
      IX_REC:    rd_val = r_rec;
      IX_PWR:    rd_val = {1'b0, r_pwr, 4'b0000, ready};
      default:   rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_slot1 <= '0;
      sts_slot2 <= '0;
      sts_tag   <= 2'b00;
      pend_rd   <= 1'b0;
      pend_idx  <= '0;
    end else if (frame_stb) begin
      if (pend_rd) begin
        sts_slot1 <= {1'b0, pend_idx, 12'h000};
        sts_slot2 <= {rd_val, 4'h0};
        sts_tag   <= 2'b11;
      end else begin
        sts_slot1 <= '0;
        sts_slot2 <= '0;
        sts_tag   <= 2'b00;
      end
      pend_rd  <= do_rd;
      pend_idx <= idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_master <= DEF_LVL;
      r_hphone <= DEF_LVL;
      r_mic    <= DEF_MIC;
      r_line   <= DEF_GAIN;
      r_cd     <= DEF_GAIN;
      r_aux    <= DEF_GAIN;
      r_pcm    <= DEF_GAIN;
      r_rec    <= DEF_REC;
      r_pwr    <= '0;
    end else if (do_wr) begin
      case (idx)
        IX_RESET: begin
          r_master <= DEF_LVL;
          r_hphone <= DEF_LVL;
          r_mic    <= DEF_MIC;
          r_line   <= DEF_GAIN;
          r_cd     <= DEF_GAIN;
          r_aux    <= DEF_GAIN;
          r_pcm    <= DEF_GAIN;
          r_rec    <= DEF_REC;
          r_pwr    <= '0;
        end
        IX_MASTER: r_master <= lvl_pack(wd);
        IX_HPHONE: r_hphone <= lvl_pack(wd);
        IX_MIC:    r_mic    <= wd & MSK_MIC;
        IX_LINE:   r_line   <= wd & MSK_GAIN;
        IX_CD:     r_cd     <= wd & MSK_GAIN;
        IX_AUX:    r_aux    <= wd & MSK_GAIN;
        IX_PCM:    r_pcm    <= wd & MSK_GAIN;
        IX_REC:    r_rec    <= wd & MSK_REC;
        IX_PWR:    r_pwr    <= 7'((wd & MSK_PWR) >> 8);
        default: ;
      endcase
    end
  end
endmodule

module codec_reg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_stb,
  input logic        frame_valid,
  input logic [1:0]  cmd_tag,
  input logic [19:12] cmd_addr,
  input logic [19:4] cmd_data,
  input logic [19:0] sts_slot1,
  input logic [19:0] sts_slot2,
  input logic [1:0]  sts_tag,
  input logic [6:0]  pd_ctrl,
  input logic        link_halt
);
  p_tag_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tag == 2'b00) || (sts_tag == 2'b11));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tag == 2'b00) |-> (sts_slot1 == 20'h0 && sts_slot2 == 20'h0));

  p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sts_slot1[19] == 1'b0 && sts_slot1[11:0] == 12'h0 && sts_slot2[3:0] == 4'h0);

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(sts_slot1) && $stable(sts_slot2) && $stable(sts_tag)));

  p_even_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tag == 2'b11) |-> (sts_slot1[12] == 1'b0));

  p_sat_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tag == 2'b11 && (sts_slot1[18:12] == 7'h02 || sts_slot1[18:12] == 7'h04))
      |-> (sts_slot2[17] == 1'b0 && sts_slot2[9] == 1'b0));

  p_ready_vs_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tag == 2'b11 && sts_slot1[18:12] == 7'h26)
      |-> (!(sts_slot2[13] && sts_slot2[5]) && !(sts_slot2[12] && sts_slot2[4])
           && !(sts_slot2[15] && sts_slot2[7])));

  p_halt_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_halt |-> pd_ctrl[4]);
endmodule

bind codec_reg_port codec_reg_port_chk u_chk (.*);

// File: tb/codec_reg_port_tb.sv
module codec_reg_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic        frame_valid = 1'b0;
  logic [1:0]  cmd_tag = 2'b00;
  logic [19:12] cmd_addr = '0;
  logic [19:4] cmd_data = '0;
  logic [19:0] sts_slot1, sts_slot2;
  logic [1:0]  sts_tag;
  logic [6:0]  pd_ctrl;
  logic        link_halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_valid(frame_valid),
    .cmd_tag(cmd_tag), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .sts_slot1(sts_slot1), .sts_slot2(sts_slot2), .sts_tag(sts_tag),
    .pd_ctrl(pd_ctrl), .link_halt(link_halt)
  );

  // {index, write value, expected read-back}
  localparam logic [38:0] VEC [15] = '{
    {7'h02, 16'h2A15, 16'h1F15},   // R5 saturate left only
    {7'h02, 16'h8E0C, 16'h8E0C},   // R5
    {7'h04, 16'hFFFF, 16'h9F1F},   // R5
    {7'h0E, 16'hFFFF, 16'h805F},   // R6
    {7'h10, 16'h7FFF, 16'h1F1F},   // R6
    {7'h12, 16'h1234, 16'h1214},   // R6
    {7'h16, 16'h8A0A, 16'h8A0A},   // R6
    {7'h18, 16'h0505, 16'h0505},   // R6
    {7'h1C, 16'hFFFF, 16'h8F0F},   // R7
    {7'h1C, 16'h0A05, 16'h0A05},   // R7
    {7'h26, 16'h0200, 16'h020D},   // R8
    {7'h26, 16'h0C0F, 16'h0C03},   // R8
    {7'h26, 16'h0100, 16'h010E},   // R8
    {7'h26, 16'h0000, 16'h000F},   // R8
    {7'h20, 16'hFFFF, 16'h0000}    // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] a, input logic [15:0] d, input logic [1:0] tg, input logic v);
    @(negedge clk);
    cmd_addr = a; cmd_data = d; cmd_tag = tg; frame_valid = v; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0; frame_valid = 1'b0; cmd_tag = 2'b00; cmd_addr = '0; cmd_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] ix, input logic [15:0] d);
    send({1'b0, ix}, d, 2'b11, 1'b1);
  endtask

  task automatic rdc(input logic [6:0] ix);
    send({1'b1, ix}, 16'h0000, 2'b10, 1'b1);
  endtask

  task automatic nop();
    send(8'h00, 16'h0000, 2'b00, 1'b1);
  endtask

  task automatic resp_chk(input string req, input logic [6:0] ix, input logic [15:0] exp);
    chk(req, {30'b0, sts_tag}, 32'h3);
    chk(req, {12'b0, sts_slot1}, {12'b0, 1'b0, ix, 12'h000});
    chk(req, {12'b0, sts_slot2}, {12'b0, exp, 4'h0});
  endtask

  task automatic read_chk(input string req, input logic [6:0] ix, input logic [15:0] exp);
    rdc(ix);
    nop();
    resp_chk(req, ix, exp);
  endtask

  task automatic defaults_chk(input string req);
    read_chk(req, 7'h02, 16'h8000);
    read_chk(req, 7'h04, 16'h8000);
    read_chk(req, 7'h0E, 16'h8008);
    read_chk(req, 7'h10, 16'h8808);
    read_chk(req, 7'h12, 16'h8808);
    read_chk(req, 7'h16, 16'h8808);
    read_chk(req, 7'h18, 16'h8808);
    read_chk(req, 7'h1C, 16'h8000);
    read_chk(req, 7'h26, 16'h000F);
    read_chk(req, 7'h2C, 16'h0000);
    chk(req, {25'b0, pd_ctrl}, 32'h0);
    chk(req, {31'b0, link_halt}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [19:0] s1, s2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 tag after reset", {30'b0, sts_tag}, 32'h0);
    chk("R9 slot1 after reset", {12'b0, sts_slot1}, 32'h0);
    defaults_chk("R9 default");

    // vector table: R5 R6 R7 R8 R9
    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][38:32], VEC[i][31:16]);
      if (VEC[i][38:32] == 7'h26)
        chk("R8 pd_ctrl", {25'b0, pd_ctrl}, {25'b0, VEC[i][30:24]});
      read_chk("R5-R9 table", VEC[i][38:32], VEC[i][15:0]);
    end

    // R8 link halt
    wr(7'h26, 16'h100F);
    chk("R8 link_halt", {31'b0, link_halt}, 32'h1);
    chk("R8 pd_ctrl halt", {25'b0, pd_ctrl}, 32'h10);
    read_chk("R8 ready unaffected by halt", 7'h26, 16'h100F);
    wr(7'h26, 16'h0000);
    chk("R8 halt release", {31'b0, link_halt}, 32'h0);

    // R3 response held between strobes, cleared after idle frame
    rdc(7'h1C);
    nop();
    s1 = sts_slot1; s2 = sts_slot2;
    repeat (5) @(negedge clk);
    chk("R3 slot1 held", {12'b0, sts_slot1}, {12'b0, s1});
    chk("R3 slot2 held", {12'b0, sts_slot2}, {12'b0, s2});
    nop();
    chk("R3 idle tag", {30'b0, sts_tag}, 32'h0);
    chk("R3 idle slot2", {12'b0, sts_slot2}, 32'h0);

    // R2 odd index ignored
    wr(7'h02, 16'h0101);
    wr(7'h03, 16'hFFFF);
    read_chk("R2 odd write ignored", 7'h02, 16'h0101);
    rdc(7'h03);
    nop();
    chk("R2 odd read no response", {30'b0, sts_tag}, 32'h0);

    // R1 tag and valid qualification
    send({1'b0, 7'h02}, 16'h1F1F, 2'b10, 1'b1);
    read_chk("R1 write without data tag", 7'h02, 16'h0101);
    send({1'b0, 7'h02}, 16'h1F1F, 2'b11, 1'b0);
    read_chk("R1 write in invalid frame", 7'h02, 16'h0101);
    send({1'b1, 7'h02}, 16'h0000, 2'b00, 1'b1);
    nop();
    chk("R1 read without address tag", {30'b0, sts_tag}, 32'h0);
    wr(7'h02, 16'h0707);
    read_chk("R1 qualified write", 7'h02, 16'h0707);

    // R4 collision: response vs same-edge write
    wr(7'h12, 16'h0303);
    rdc(7'h12);
    wr(7'h12, 16'h0000);
    resp_chk("R4 old value on collision", 7'h12, 16'h0303);
    read_chk("R4 new value after", 7'h12, 16'h0000);

    // R4 + R10 collision with register reset
    wr(7'h26, 16'h0F00);
    rdc(7'h26);
    wr(7'h00, 16'h1234);
    resp_chk("R4 pre-reset response", 7'h26, 16'h0F00);
    defaults_chk("R10 register reset");

    // R9 cold reset mid-run
    wr(7'h0E, 16'h0040);
    wr(7'h26, 16'h0400);
    rdc(7'h0E);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nop();
    chk("R9 pending read dropped by cold reset", {30'b0, sts_tag}, 32'h0);
    defaults_chk("R9 cold reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule